// File: doc/BRIEF.md
# UART Modem Control and Status with Automatic Flow Control

This block is the modem-line side of a 16550-style UART. Software writes a small control register whose two low bits drive the active-low data-terminal-ready and request-to-send pins. It reads a status register that reports the four active-low modem inputs (clear-to-send, data-set-ready, ring indicator, carrier detect) as inverted, synchronised levels, together with sticky flags that record which lines have changed since the last read. A modem-status interrupt is raised while its enable bit is set and any change flag is pending.

On top of that register pair, a flow register turns on automatic hardware flow control, one bit per direction. With automatic clear-to-send on, the `tx_allowed` output tells the transmitter whether it may start a new character. The transmitter samples it only before a start bit, so a character already on the line is completed. With automatic request-to-send on, the block compares the receive FIFO fill level with a trigger level. It deasserts request-to-send when the trigger is reached and asserts it again once the level has fallen by more than a fixed hysteresis.

Top module: `uart_mdm_flow_ctl`

## Requirements
- R1: After a write to address 0, `dtr_n` is the complement of bit 0 of the written value.
- R2: With automatic request-to-send off, `rts_n` is the complement of bit 1 of the address-0 register. When that bit is 0, `rts_n` is 1 in every mode.
- R3: After reset, `dtr_n` and `rts_n` are 1, `irq_msr` is 0, `tx_allowed` is 1, and all register fields and change flags are 0.
- R4: Status register (address 1) bits 4, 5, 6 and 7 show the inverted `cts_n`, `dsr_n`, `ri_n` and `dcd_n` inputs, delayed by SYNC_STAGES clock edges.
- R5: Status bits 0, 1 and 3 are set by any change of the synchronised clear-to-send, data-set-ready and carrier-detect levels. Bit 2 is set only when `ri_n` goes from 0 to 1. The flags are set in the same cycle as the changed level appears in bits 4 to 7.
- R6: A cycle with `reg_rd` high at address 1 clears the change flags at the next edge. A change detected at that same edge still leaves its flag set.
- R7: `irq_msr` is 1 exactly when address-3 bit 0 is set and at least one change flag is set.
- R8: With address-2 bit 7 set, `tx_allowed` equals the synchronised clear-to-send level. With that bit clear, `tx_allowed` is 1.
- R9: With address-2 bit 6 set, an internal hold is set at the first edge where `rx_level >= rx_trigger`. It is cleared at an edge where `rx_level + HYST < rx_trigger` or `rx_level == 0`. While the hold is set, `rts_n` is 1. Turning bit 6 off clears the hold.
- R10: The data-set-ready, ring and carrier-detect inputs have no effect on `tx_allowed` or `rts_n`.
- R11: Reading address 0 returns {6'b0, bit1, bit0}. Reading address 2 returns {bit7, bit6, 6'b0}. Reading address 3 returns {7'b0, bit0}. Unused written bits are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears change flags at address 1) |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 flow, 3 interrupt enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for the selected register |
| cts_n | input | 1 | Clear-to-send, active low, asynchronous |
| dsr_n | input | 1 | Data-set-ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| dtr_n | output | 1 | Data-terminal-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| irq_msr | output | 1 | Modem-status interrupt |
| tx_allowed | output | 1 | Transmitter may begin a new character |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trigger | input | LVL_W | Receive trigger level for automatic request-to-send |

## Verification
The assertions check several rules on every cycle. They check the pin value that follows a control write and the release of request-to-send whenever its register bit is clear. They check that a change flag survives any cycle that is not a status read, that the interrupt never rises without a pending flag, and that `tx_allowed` matches the live clear-to-send level or is forced high. Other behaviour can only be shown by the bench's scenarios. These cover the synchroniser latency and the ring flag firing on the trailing edge only. They also cover a read-clear that collides with a fresh change, and the exact fill levels at which the automatic request-to-send hold sets and releases around the hysteresis band.

// File: rtl/uart_mdm_pkg.sv
// Shared register addresses, bit positions and line bundle for the
// modem-control block. Assumes a 2-bit register select.
package uart_mdm_pkg;

    typedef enum logic [1:0] {
        ADR_MCTL  = 2'd0,
        ADR_MSTAT = 2'd1,
        ADR_FLOW  = 2'd2,
        ADR_IEN   = 2'd3
    } mdm_addr_e;

    localparam int BIT_DTR   = 0;
    localparam int BIT_RTS   = 1;
    localparam int BIT_ARTS  = 6;
    localparam int BIT_ACTS  = 7;
    localparam int BIT_MSIEN = 0;

    // Index order of the four modem lines inside every 4-bit bundle
    localparam int LN_CTS = 0;
    localparam int LN_DSR = 1;
    localparam int LN_RI  = 2;
    localparam int LN_DCD = 3;
    localparam int NLINES = 4;

endpackage

// File: rtl/mdm_regs.sv
// Writable configuration registers: control (DTR/RTS request bits),
// flow enables and interrupt enable. Assumes writes are single-cycle strobes.
module mdm_regs
    import uart_mdm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [1:0] addr,
    input  logic [7:0] wr_data,
    output logic       req_dtr,
    output logic       req_rts,
    output logic       auto_cts,
    output logic       auto_rts,
    output logic       msi_en
);

    // Capture register fields on a write strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_dtr  <= 1'b0;
            req_rts  <= 1'b0;
            auto_cts <= 1'b0;
            auto_rts <= 1'b0;
            msi_en   <= 1'b0;
        end else if (wr_en) begin
            case (mdm_addr_e'(addr))
                ADR_MCTL: begin
                    req_dtr <= wr_data[BIT_DTR];
                    req_rts <= wr_data[BIT_RTS];
                end
                ADR_FLOW: begin
                    auto_cts <= wr_data[BIT_ACTS];
                    auto_rts <= wr_data[BIT_ARTS];
                end
                ADR_IEN:  msi_en <= wr_data[BIT_MSIEN];
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/mdm_status.sv
// Synchronises the four active-low modem inputs and keeps sticky change
// flags. Assumes SYNC_STAGES >= 2; the ring flag fires on ring end only.
module mdm_status
    import uart_mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] lines_n,
    input  logic              clr,
    output logic [NLINES-1:0] live,
    output logic [NLINES-1:0] delta
);

    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0][NLINES-1:0] stg;
    logic [NLINES-1:0] fresh;

    // Shift the inverted inputs through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= '0;
        else        stg <= {stg[LAST-1:0], ~lines_n};
    end

    // Detect the change that the final stage is about to take
    always_comb begin
        fresh         = stg[LAST-1] ^ stg[LAST];
        fresh[LN_RI]  = stg[LAST][LN_RI] & ~stg[LAST-1][LN_RI];
    end

    // Sticky flags, cleared by a status read; a new change wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) delta <= '0;
        else        delta <= (clr ? '0 : delta) | fresh;
    end

    assign live = stg[LAST];

endmodule

// File: rtl/mdm_flow.sv
// Automatic flow control: receive-level hold with hysteresis driving RTS,
// and CTS gating of new transmit characters. Assumes HYST < 2**LVL_W.
module mdm_flow #(
    parameter int LVL_W = 8,
    parameter int HYST  = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             auto_cts,
    input  logic             auto_rts,
    input  logic             req_rts,
    input  logic             cts_live,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trigger,
    output logic             rts_n,
    output logic             tx_allowed
);

    localparam logic [LVL_W:0] HYST_W = (LVL_W+1)'(HYST);

    logic           hold;
    logic [LVL_W:0] lvl_plus;
    logic           at_trig;
    logic           below_band;

    // Compare fill level against trigger and release threshold
    always_comb begin
        lvl_plus   = {1'b0, rx_level} + HYST_W;
        at_trig    = rx_level >= rx_trigger;
        below_band = (lvl_plus < {1'b0, rx_trigger}) || (rx_level == '0);
    end

    // Receive hold state with hysteresis
    always_ff @(posedge clk) begin
        if (!rst_n || !auto_rts) hold <= 1'b0;
        else if (at_trig)        hold <= 1'b1;
        else if (below_band)     hold <= 1'b0;
    end

    assign rts_n      = ~(req_rts & ~hold);
    assign tx_allowed = ~auto_cts | cts_live;

endmodule

// File: rtl/uart_mdm_flow_ctl.sv
// Top of the modem-control block: register read mux, pin drive and the
// modem-status interrupt. Assumes a single-cycle read strobe per access.
module uart_mdm_flow_ctl
    import uart_mdm_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int LVL_W       = 8,
    parameter int HYST        = 4
)(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [1:0]       reg_addr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic             cts_n,
    input  logic             dsr_n,
    input  logic             ri_n,
    input  logic             dcd_n,
    output logic             dtr_n,
    output logic             rts_n,
    output logic             irq_msr,
    output logic             tx_allowed,
    input  logic [LVL_W-1:0] rx_level,
    input  logic [LVL_W-1:0] rx_trigger
);

    logic              req_dtr, req_rts, auto_cts, auto_rts, msi_en;
    logic [NLINES-1:0] live, delta, lines_n;
    logic              stat_clr;

    assign lines_n  = {dcd_n, ri_n, dsr_n, cts_n};
    assign stat_clr = reg_rd && (mdm_addr_e'(reg_addr) == ADR_MSTAT);

    mdm_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wr_data(wr_data), .req_dtr(req_dtr), .req_rts(req_rts),
        .auto_cts(auto_cts), .auto_rts(auto_rts), .msi_en(msi_en)
    );

    mdm_status #(.SYNC_STAGES(SYNC_STAGES)) u_stat (
        .clk(clk), .rst_n(rst_n), .lines_n(lines_n), .clr(stat_clr),
        .live(live), .delta(delta)
    );

    mdm_flow #(.LVL_W(LVL_W), .HYST(HYST)) u_flow (
        .clk(clk), .rst_n(rst_n), .auto_cts(auto_cts), .auto_rts(auto_rts),
        .req_rts(req_rts), .cts_live(live[LN_CTS]), .rx_level(rx_level),
        .rx_trigger(rx_trigger), .rts_n(rts_n), .tx_allowed(tx_allowed)
    );

    // Select read data for the addressed register
    always_comb begin
        case (mdm_addr_e'(reg_addr))
            ADR_MCTL:  rd_data = {6'b0, req_rts, req_dtr};
            ADR_MSTAT: rd_data = {live, delta};
            ADR_FLOW:  rd_data = {auto_cts, auto_rts, 6'b0};
            default:   rd_data = {7'b0, msi_en};
        endcase
    end

    assign dtr_n   = ~req_dtr;
    assign irq_msr = msi_en & (|delta);

endmodule

// File: rtl/uart_mdm_chk.sv
// Checker for uart_mdm_flow_ctl, attached with bind below.
module uart_mdm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [1:0] reg_addr,
    input logic [7:0] wr_data,
    input logic       dtr_n,
    input logic       rts_n,
    input logic       irq_msr,
    input logic       tx_allowed,
    input logic       req_rts,
    input logic       auto_cts,
    input logic [3:0] live,
    input logic [3:0] delta
);

    AST_DTR_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd0) |=> (dtr_n == !$past(wr_data[0]))); // R1

    AST_RTS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !req_rts |-> rts_n); // R2

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd && reg_addr == 2'd1) |=> (($past(delta) & ~delta) == 4'd0)); // R6

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msr |-> (delta != 4'd0)); // R7

    AST_TX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_allowed == (!auto_cts || live[0])); // R8

endmodule

bind uart_mdm_flow_ctl uart_mdm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .wr_data(wr_data), .dtr_n(dtr_n), .rts_n(rts_n),
    .irq_msr(irq_msr), .tx_allowed(tx_allowed), .req_rts(req_rts),
    .auto_cts(auto_cts), .live(live), .delta(delta)
);

// File: tb/sim_uart_mdm_flow_ctl.sv
module sim_uart_mdm_flow_ctl;

    localparam int SYNC = 2;
    localparam int LW   = 8;
    localparam int HY   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]    reg_addr = 2'd0;
    logic [7:0]    wr_data = 8'd0;
    logic [7:0]    rd_data;
    logic          cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b1;
    logic          dtr_n, rts_n, irq_msr, tx_allowed;
    logic [LW-1:0] rx_level = '0, rx_trigger = 8'd16;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    uart_mdm_flow_ctl #(.SYNC_STAGES(SYNC), .LVL_W(LW), .HYST(HY)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .wr_data(wr_data), .rd_data(rd_data),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .dtr_n(dtr_n), .rts_n(rts_n), .irq_msr(irq_msr),
        .tx_allowed(tx_allowed), .rx_level(rx_level), .rx_trigger(rx_trigger)
    );

    // Behavioural reference model
    bit         m_dtr, m_rts, m_acts, m_arts, m_ien, m_hold;
    logic [3:0] m_flag;
    logic [3:0] m_pipe[$];
    logic [3:0] m_old, m_new, m_fresh;

    function automatic logic [3:0] m_live();
        return m_pipe[SYNC-1];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            {m_dtr, m_rts, m_acts, m_arts, m_ien, m_hold} = '0;
            m_flag = 4'd0;
            m_pipe = {};
            for (int i = 0; i < SYNC; i++) m_pipe.push_back(4'd0);
        end else begin
            m_pipe.push_front(~{dcd_n, ri_n, dsr_n, cts_n});
            m_old = m_pipe[SYNC];
            m_new = m_pipe[SYNC-1];
            void'(m_pipe.pop_back());
            m_fresh    = (m_old ^ m_new) & 4'b1011;
            m_fresh[2] = m_old[2] && !m_new[2];
            if (reg_rd && reg_addr == 2'd1) m_flag = 4'd0;
            m_flag = m_flag | m_fresh;
            if (!m_arts) m_hold = 0;
            else if (int'(rx_level) >= int'(rx_trigger)) m_hold = 1;
            else if (int'(rx_level) + HY < int'(rx_trigger) || rx_level == 0) m_hold = 0;
            if (reg_wr) begin
                case (reg_addr)
                    2'd0: begin m_dtr = wr_data[0]; m_rts = wr_data[1]; end
                    2'd2: begin m_acts = wr_data[7]; m_arts = wr_data[6]; end
                    2'd3: m_ien = wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] m_rd();
        case (reg_addr)
            2'd0: return {6'b0, m_rts, m_dtr};
            2'd1: return {m_live(), m_flag};
            2'd2: return {m_acts, m_arts, 6'b0};
            default: return {7'b0, m_ien};
        endcase
    endfunction

    // Compare every output against the model each cycle, mid-period
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R1 dtr_n", {7'b0, dtr_n}, {7'b0, !m_dtr});
            check("R2 R9 rts_n", {7'b0, rts_n}, {7'b0, !(m_rts && !m_hold)});
            check("R7 irq_msr", {7'b0, irq_msr}, {7'b0, m_ien && (m_flag != 0)});
            check("R8 tx_allowed", {7'b0, tx_allowed}, {7'b0, !m_acts || m_live()[0]});
            check("R4 R5 R6 R11 rd_data", rd_data, m_rd());
        end
    end

    task automatic tick(input int n = 1);
        repeat (n) begin
            @(posedge clk);
            #2;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; wr_data = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_clear();
        reg_addr = 2'd1; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0;
    endtask

    initial begin
        #200000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick();
        // R3 reset state
        check("R3 dtr_n", {7'b0, dtr_n}, 8'd1);
        check("R3 rts_n", {7'b0, rts_n}, 8'd1);
        check("R3 irq", {7'b0, irq_msr}, 8'd0);
        check("R3 tx_allowed", {7'b0, tx_allowed}, 8'd1);
        reg_addr = 2'd1; #1;
        check("R3 status", rd_data, 8'h00);

        // R1 R2 control pins
        wr(2'd0, 8'h01);
        check("R1 dtr low", {7'b0, dtr_n}, 8'd0);
        check("R2 rts idle", {7'b0, rts_n}, 8'd1);
        wr(2'd0, 8'h03);
        check("R2 rts low", {7'b0, rts_n}, 8'd0);
        wr(2'd0, 8'hFE);
        check("R1 dtr high", {7'b0, dtr_n}, 8'd1);
        reg_addr = 2'd0; #1;
        check("R11 ctl readback", rd_data, 8'h02);
        wr(2'd2, 8'hFF);
        reg_addr = 2'd2; #1;
        check("R11 flow readback", rd_data, 8'hC0);
        wr(2'd2, 8'h00);

        // R4 R5 R6 clear-to-send change and read clear
        cts_n = 1'b0;
        reg_addr = 2'd1;
        tick(4);
        check("R4 R5 cts live+flag", rd_data, 8'h11);
        rd_clear();
        reg_addr = 2'd1; #1;
        check("R6 flags cleared", rd_data, 8'h10);

        // R5 ring flag only at ring end
        ri_n = 1'b0;
        tick(4);
        check("R5 ring start no flag", rd_data, 8'h50);
        ri_n = 1'b1;
        tick(4);
        check("R5 ring end flag", rd_data, 8'h14);

        // R7 interrupt enable gating
        check("R7 irq masked", {7'b0, irq_msr}, 8'd0);
        wr(2'd3, 8'h01);
        check("R7 irq raised", {7'b0, irq_msr}, 8'd1);
        rd_clear();
        check("R7 irq dropped", {7'b0, irq_msr}, 8'd0);

        // R6 change detected on the same edge as a clear
        dsr_n = 1'b0;
        tick();
        reg_addr = 2'd1; reg_rd = 1'b1;
        tick();
        reg_rd = 1'b0; #1;
        check("R6 collide keeps flag", rd_data, 8'h32);
        check("R7 irq on collide", {7'b0, irq_msr}, 8'd1);
        rd_clear();

        // R8 R10 automatic clear-to-send
        wr(2'd2, 8'h80);
        check("R8 cts on allows", {7'b0, tx_allowed}, 8'd1);
        cts_n = 1'b1;
        tick(4);
        check("R8 cts off blocks", {7'b0, tx_allowed}, 8'd0);
        dsr_n = 1'b1; dcd_n = 1'b0; ri_n = 1'b0;
        tick(4);
        check("R10 tx unaffected", {7'b0, tx_allowed}, 8'd0);
        check("R10 rts unaffected", {7'b0, rts_n}, 8'd0);
        cts_n = 1'b0; ri_n = 1'b1;
        tick(4);
        check("R8 cts back", {7'b0, tx_allowed}, 8'd1);
        wr(2'd2, 8'h00);
        cts_n = 1'b1;
        tick(4);
        check("R8 gate off", {7'b0, tx_allowed}, 8'd1);
        rd_clear();

        // R9 automatic request-to-send with hysteresis (trigger 16, band 4)
        wr(2'd2, 8'h40);
        rx_level = 8'd15; tick();
        check("R9 below trigger", {7'b0, rts_n}, 8'd0);
        rx_level = 8'd16; tick();
        check("R9 at trigger", {7'b0, rts_n}, 8'd1);
        rx_level = 8'd13; tick();
        check("R9 inside band", {7'b0, rts_n}, 8'd1);
        rx_level = 8'd12; tick();
        check("R9 band edge", {7'b0, rts_n}, 8'd1);
        rx_level = 8'd11; tick();
        check("R9 released", {7'b0, rts_n}, 8'd0);
        rx_level = 8'd40; tick();
        wr(2'd0, 8'h00);
        check("R2 rts bit clear", {7'b0, rts_n}, 8'd1);
        wr(2'd0, 8'h02);
        check("R9 hold kept", {7'b0, rts_n}, 8'd1);
        wr(2'd2, 8'h00);
        tick();
        check("R9 auto off", {7'b0, rts_n}, 8'd0);
        tick(3);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule